// File: doc/BRIEF.md
# Program Space Visibility Address Mapper

This block sits on the X-side read path of a processor. It lets constant data stored in a 24-bit-wide program memory be read with ordinary 16-bit data reads. A read whose effective address has bit 15 set is routed to program memory. This happens only when the visibility enable bit is set, no table read or table write is in progress, and the read comes from the X bus. The program address is built from an 8-bit page register placed above the low 15 address bits. Only the low 16 bits of the fetched program word come back as read data. Any other read goes unchanged to the synchronous data RAM port.

A routed read takes two back-to-back program memory fetches, both to the same address. The mapper raises a stall for the one cycle in which an unmapped read would already have delivered its data. While the stall is high it ignores any request. The read-data-valid flag then rises for exactly one cycle. The page register and the enable bit are written through their own write strobes. A write is registered, so it first affects the request in the cycle after the write.

Top module: `psv_mapper`

## Requirements
- R1: After reset, stall, rd_valid, pm_re and ram_re are 0, rd_data is 0, the page register holds 0x00 and the enable bit is 0, so a read at 0x8000 goes to the RAM port.
- R2: A request accepted while req_xbus=1, req_addr[15]=1, the enable bit is 1 and tbl_busy=0 raises pm_re in the same cycle and leaves ram_re at 0.
- R3: A mapped read drives pm_addr = {page[7:0], req_addr[14:0]} (23 bits, page in bits 22:15) on its first fetch, and the same address on its second fetch.
- R4: The two fetches of a mapped read fall on consecutive cycles. stall is high only in the cycle after acceptance, and rd_valid is high for exactly one cycle, two cycles after acceptance.
- R5: The data returned for a mapped read is bits 15:0 of the word that program memory returns for the second fetch; bits 23:16 are dropped.
- R6: An accepted read that is not mapped raises ram_re with ram_addr = req_addr in the same cycle. rd_valid follows one cycle later with ram_rdata, and stall stays 0.
- R7: While tbl_busy=1, a read in the upper half goes to the RAM port even with the enable bit set.
- R8: A read with req_xbus=0 (Y bus) is never mapped and goes to the RAM port.
- R9: A write to the page register or the enable bit is used by requests from the next cycle on; a request in the same cycle as the write uses the old value.
- R10: A request presented while stall is high is ignored: it causes no ram_re, no new fetch and no rd_valid.
- R11: rd_data is 0 whenever rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Data read request |
| req_xbus | input | 1 | 1 = request from the X bus, 0 = Y bus |
| req_addr | input | 16 | Effective data address |
| tbl_busy | input | 1 | Table read/write in progress; blocks mapping |
| page_we | input | 1 | Page register write strobe |
| page_wdata | input | 8 | Page register write value |
| en_we | input | 1 | Enable bit write strobe |
| en_wdata | input | 1 | Enable bit write value |
| stall | output | 1 | Extra cycle of a mapped read; requests ignored |
| rd_valid | output | 1 | Read data valid, one cycle per read |
| rd_data | output | 16 | Read data, 0 when not valid |
| ram_re | output | 1 | Data RAM read strobe |
| ram_addr | output | 16 | Data RAM address |
| ram_rdata | input | 16 | Data RAM read data, one cycle after ram_re |
| pm_re | output | 1 | Program memory read strobe |
| pm_addr | output | 23 | Program memory word address |
| pm_rdata | input | 24 | Program memory read data, one cycle after pm_re |

## Verification
The hardest case to reach is a request that arrives in the stall cycle. Others are a configuration write in the same cycle as a mapped request, and a new request that lands in the delivery cycle of the previous read. The bench drives each of these cases directly: it holds req_valid high through a stall, writes the page together with a request, and issues reads back to back. A long run of random inputs then follows, with tbl_busy, the Y-bus flag and the enable writes switching often. A behavioural model schedules every expected fetch, stall and data delivery by cycle number and compares all outputs on every clock.

// File: rtl/psv_pkg.sv
package psv_pkg;

    // Phase of the read that is in flight
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_RAMDATA = 2'd1,
        PH_REFETCH = 2'd2,
        PH_PMDATA  = 2'd3
    } psv_phase_e;

endpackage

// File: rtl/psv_cfg_regs.sv
module psv_cfg_regs #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_wdata,
    input  logic              en_we,
    input  logic              en_wdata,
    output logic [PAGE_W-1:0] page_q,
    output logic              en_q
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (page_we) cfg_d.page = page_wdata;
        if (en_we)   cfg_d.en   = en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign page_q = cfg_q.page;
    assign en_q   = cfg_q.en;

endmodule

// File: rtl/psv_window_dec.sv
module psv_window_dec #(
    parameter int EA_W   = 16,
    parameter int PAGE_W = 8,
    localparam int OFS_W = EA_W - 1,
    localparam int PA_W  = PAGE_W + OFS_W
) (
    input  logic              accept,
    input  logic              req_xbus,
    input  logic [EA_W-1:0]   req_addr,
    input  logic              en,
    input  logic              tbl_busy,
    input  logic [PAGE_W-1:0] page,
    output logic              map_hit,
    output logic              ram_pass,
    output logic [PA_W-1:0]   prog_addr
);

    logic in_window;

    always_comb begin
        // top address bit selects the upper half of data space
        in_window = req_addr[EA_W-1] & en & req_xbus & ~tbl_busy;
        map_hit   = accept & in_window;
        ram_pass  = accept & ~in_window;
        prog_addr = {page, req_addr[OFS_W-1:0]};
    end

endmodule

// File: rtl/psv_fetch_seq.sv
module psv_fetch_seq
    import psv_pkg::*;
#(
    parameter int PA_W = 23
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            map_hit,
    input  logic            ram_pass,
    input  logic [PA_W-1:0] prog_addr,
    output logic            stall,
    output logic            pm_re,
    output logic [PA_W-1:0] pm_addr,
    output logic            deliver_ram,
    output logic            deliver_pm
);

    typedef struct packed {
        psv_phase_e      phase;
        logic [PA_W-1:0] addr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (map_hit) begin
            seq_d.phase = PH_REFETCH;
            seq_d.addr  = prog_addr;
        end else if (ram_pass) begin
            seq_d.phase = PH_RAMDATA;
        end else if (seq_q.phase == PH_REFETCH) begin
            seq_d.phase = PH_PMDATA;
        end else begin
            seq_d.phase = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PH_IDLE, addr: '0};
        else        seq_q <= seq_d;
    end

    always_comb begin
        stall       = (seq_q.phase == PH_REFETCH);
        deliver_ram = (seq_q.phase == PH_RAMDATA);
        deliver_pm  = (seq_q.phase == PH_PMDATA);
        pm_re       = map_hit | stall;
        pm_addr     = stall ? seq_q.addr : prog_addr;
    end

endmodule

// File: rtl/psv_mapper.sv
module psv_mapper #(
    parameter int EA_W   = 16,
    parameter int PAGE_W = 8,
    parameter int PW_W   = 24,
    parameter int DW     = 16,
    localparam int PA_W  = PAGE_W + EA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_xbus,
    input  logic [EA_W-1:0]   req_addr,
    input  logic              tbl_busy,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_wdata,
    input  logic              en_we,
    input  logic              en_wdata,
    output logic              stall,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              ram_re,
    output logic [EA_W-1:0]   ram_addr,
    input  logic [DW-1:0]     ram_rdata,
    output logic              pm_re,
    output logic [PA_W-1:0]   pm_addr,
    input  logic [PW_W-1:0]   pm_rdata
);

    logic [PAGE_W-1:0] page_q;
    logic              en_q;
    logic              accept;
    logic              map_hit;
    logic              ram_pass;
    logic [PA_W-1:0]   prog_addr;
    logic              deliver_ram;
    logic              deliver_pm;
    logic              unused_upper;

    psv_cfg_regs #(.PAGE_W(PAGE_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_we    (page_we),
        .page_wdata (page_wdata),
        .en_we      (en_we),
        .en_wdata   (en_wdata),
        .page_q     (page_q),
        .en_q       (en_q)
    );

    // requests are ignored during the extra fetch cycle
    assign accept = req_valid & ~stall;

    psv_window_dec #(.EA_W(EA_W), .PAGE_W(PAGE_W)) u_dec (
        .accept    (accept),
        .req_xbus  (req_xbus),
        .req_addr  (req_addr),
        .en        (en_q),
        .tbl_busy  (tbl_busy),
        .page      (page_q),
        .map_hit   (map_hit),
        .ram_pass  (ram_pass),
        .prog_addr (prog_addr)
    );

    psv_fetch_seq #(.PA_W(PA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .map_hit     (map_hit),
        .ram_pass    (ram_pass),
        .prog_addr   (prog_addr),
        .stall       (stall),
        .pm_re       (pm_re),
        .pm_addr     (pm_addr),
        .deliver_ram (deliver_ram),
        .deliver_pm  (deliver_pm)
    );

    assign ram_re       = ram_pass;
    assign ram_addr     = req_addr;
    assign unused_upper = ^pm_rdata[PW_W-1:DW];

    always_comb begin
        rd_valid = deliver_ram | deliver_pm;
        rd_data  = '0;
        if (deliver_pm)       rd_data = pm_rdata[DW-1:0];
        else if (deliver_ram) rd_data = ram_rdata;
    end

endmodule

// File: rtl/psv_mapper_chk.sv
module psv_mapper_chk #(
    parameter int PA_W = 23,
    parameter int DW   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_xbus,
    input logic            tbl_busy,
    input logic            stall,
    input logic            rd_valid,
    input logic [DW-1:0]   rd_data,
    input logic            pm_re,
    input logic [PA_W-1:0] pm_addr,
    input logic            ram_re
);

    // R2
    exclusive_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pm_re && ram_re));

    // R4
    first_fetch_then_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_re && !stall) |=> stall);

    // R4
    stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!stall && rd_valid));

    // R3
    refetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (pm_re && pm_addr == $past(pm_addr)));

    // R6
    ram_delivery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> (rd_valid && !stall));

    // R7
    table_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_busy && !stall) |-> !pm_re);

    // R8
    ybus_to_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_xbus && !stall) |-> ram_re);

    // R10
    stall_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !ram_re);

    // R11
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

endmodule

bind psv_mapper psv_mapper_chk #(.PA_W(PA_W), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_xbus  (req_xbus),
    .tbl_busy  (tbl_busy),
    .stall     (stall),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .pm_re     (pm_re),
    .pm_addr   (pm_addr),
    .ram_re    (ram_re)
);

// File: tb/psv_mapper_bench.sv
`timescale 1ns/1ps
module psv_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_xbus = 0, tbl_busy = 0;
    logic [15:0] req_addr = '0;
    logic        page_we = 0, en_we = 0, en_wdata = 0;
    logic [7:0]  page_wdata = '0;
    logic        stall, rd_valid, ram_re, pm_re;
    logic [15:0] rd_data, ram_addr, ram_rdata;
    logic [22:0] pm_addr;
    logic [23:0] pm_rdata;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    string cur_tag = "R1";

    // reference model state
    logic [7:0]  m_page = 8'h00;
    logic        m_en = 1'b0;
    bit          s_stall[int];
    logic [22:0] s_paddr[int];
    bit          s_rv[int];
    logic [15:0] s_rd[int];

    always #2.5 clk = ~clk;

    psv_mapper u_psv_mapper (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_xbus(req_xbus),
        .req_addr(req_addr), .tbl_busy(tbl_busy), .page_we(page_we),
        .page_wdata(page_wdata), .en_we(en_we), .en_wdata(en_wdata),
        .stall(stall), .rd_valid(rd_valid), .rd_data(rd_data),
        .ram_re(ram_re), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .pm_re(pm_re), .pm_addr(pm_addr), .pm_rdata(pm_rdata)
    );

    function automatic logic [23:0] pm_word(logic [22:0] a);
        return {a[22:15] ^ 8'hC3, a[15:0] ^ 16'h5A5A};
    endfunction

    function automatic logic [15:0] ram_word(logic [15:0] a);
        return a ^ 16'h1234;
    endfunction

    // behavioural synchronous memories
    always @(posedge clk) begin
        if (pm_re)  pm_rdata  <= pm_word(pm_addr);
        if (ram_re) ram_rdata <= ram_word(ram_addr);
    end

    task automatic cmp(string sig, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d %s: actual %h expected %h", cur_tag, cyc, sig, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // called at a negedge with inputs already set
    task automatic step();
        bit          e_stall, acc, hit, e_pm, e_ram, e_rv;
        logic [22:0] e_paddr;
        logic [15:0] e_rd;
        #1;
        e_stall = s_stall.exists(cyc);
        acc     = req_valid && !e_stall;
        hit     = acc && req_xbus && req_addr[15] && m_en && !tbl_busy;
        e_pm    = hit || e_stall;
        e_paddr = hit ? {m_page, req_addr[14:0]} : (e_stall ? s_paddr[cyc] : 23'd0);
        e_ram   = acc && !hit;
        e_rv    = s_rv.exists(cyc);
        e_rd    = e_rv ? s_rd[cyc] : 16'h0;
        cmp("stall", 32'(stall), 32'(e_stall));
        cmp("rd_valid", 32'(rd_valid), 32'(e_rv));
        cmp("rd_data", 32'(rd_data), 32'(e_rd));
        cmp("pm_re", 32'(pm_re), 32'(e_pm));
        if (e_pm) cmp("pm_addr", 32'(pm_addr), 32'(e_paddr));
        cmp("ram_re", 32'(ram_re), 32'(e_ram));
        if (e_ram) cmp("ram_addr", 32'(ram_addr), 32'(req_addr));
        if (hit) begin
            s_stall[cyc+1] = 1;
            s_paddr[cyc+1] = e_paddr;
            s_rv[cyc+2]    = 1;
            s_rd[cyc+2]    = pm_word(e_paddr)[15:0];
        end else if (e_ram) begin
            s_rv[cyc+1] = 1;
            s_rd[cyc+1] = ram_word(req_addr);
        end
        @(posedge clk);
        if (page_we) m_page = page_wdata;
        if (en_we)   m_en   = en_wdata;
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 0; page_we = 0; en_we = 0; tbl_busy = 0; req_xbus = 1;
    endtask

    task automatic rd(logic [15:0] a, logic xb, logic tb);
        req_valid = 1; req_addr = a; req_xbus = xb; tbl_busy = tb;
        step();
        idle();
    endtask

    task automatic settle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        cur_tag = "R1";
        cmp("reset stall", 32'(stall), 0);
        cmp("reset rd_valid", 32'(rd_valid), 0);
        cmp("reset pm_re", 32'(pm_re), 0);
        rst_n = 1;
        settle(2);
        // R1: enable off after reset -> upper-half read goes to RAM
        rd(16'h8000, 1, 0); settle(2);

        cur_tag = "R9";
        en_we = 1; en_wdata = 1; page_we = 1; page_wdata = 8'h12;
        step(); idle();

        cur_tag = "R2 R3 R4 R5";
        rd(16'h8004, 1, 0); settle(3);
        rd(16'hFFFF, 1, 0); settle(3);

        cur_tag = "R6";
        rd(16'h1234, 1, 0); settle(2);
        rd(16'h7FFF, 1, 0); settle(2);

        cur_tag = "R7";
        rd(16'h8010, 1, 1); settle(2);

        cur_tag = "R8";
        rd(16'h9000, 0, 0); settle(2);

        cur_tag = "R9";
        page_we = 1; page_wdata = 8'h34;
        req_valid = 1; req_addr = 16'h8100; req_xbus = 1;
        step(); idle(); settle(3);
        rd(16'h8100, 1, 0); settle(3);
        en_we = 1; en_wdata = 0; req_valid = 1; req_addr = 16'hC000;
        step(); idle(); settle(3);
        rd(16'hC000, 1, 0); settle(2);
        en_we = 1; en_wdata = 1; page_we = 1; page_wdata = 8'hFF;
        step(); idle();

        cur_tag = "R10";
        req_valid = 1; req_addr = 16'hA5A0; req_xbus = 1;
        step();
        req_addr = 16'h0042;
        step();
        idle(); settle(3);

        cur_tag = "R4 R6 back-to-back";
        req_valid = 1; req_addr = 16'h0100; step();
        req_addr = 16'h8200; step(); step();
        req_addr = 16'h0300; step();
        req_addr = 16'h8400; step(); step(); step();
        idle(); settle(3);

        cur_tag = "R11 random";
        for (int i = 0; i < 3000; i++) begin
            req_valid  = ($urandom_range(0, 3) != 0);
            req_addr   = 16'($urandom);
            req_xbus   = ($urandom_range(0, 4) != 0);
            tbl_busy   = ($urandom_range(0, 5) == 0);
            page_we    = ($urandom_range(0, 7) == 0);
            page_wdata = 8'($urandom);
            en_we      = ($urandom_range(0, 15) == 0);
            en_wdata   = ($urandom_range(0, 3) != 0);
            step();
        end
        idle(); settle(4);
        summary();
    end

endmodule